// File: doc/BRIEF.md
# Unipolar H-Bridge Gate Sequencer

This block produces the four gate commands of a single-phase full bridge driven with unipolar switching. In each half of the line cycle one top switch is pulse-width modulated at the switching frequency under cycle-by-cycle current trip control. The bottom switch of the opposite leg is held on for the whole half-cycle. The other top and bottom switches stay off. The half-cycle in force is taken from a polarity input. It is applied only at the start of a switching period, so the pattern and the trip sense always change together.

An external comparator reports whether the sensed current is above the reference. While the polarity is positive, that report ends the on-time at the current peak. While it is negative, the report is inverted, so the on-time ends at the current valley instead. For a programmable number of clock cycles after each applied polarity change, trip reports are ignored. This avoids a one-period mismatch between the new pattern and a stale trip. Every gate turns on only after a programmable dead time, and a final interlock forces both switches of a leg off if they would ever be commanded on together. Reset and a low enable hold all four gates off.

Top module: `hbridge_unipolar_seq`

## Requirements
- R1: All four gates are low while `rst_n` is low. All four are also low from the first clock edge at which `enable` is sampled low, for as long as it stays low.
- R2: The switching period is `period_cycles` clocks (a value of at least 2). The modulating top switch is commanded on at the first edge of every period. With `dead_cycles`=0 and a trip in every cycle, the top gate gives one-clock pulses spaced exactly `period_cycles` clocks apart.
- R3: The applied polarity is taken from `polarity` only at the first edge of a period. Polarity 1 (positive) selects leg A top modulating with leg B bottom on. Polarity 0 (negative) selects leg B top modulating with leg A bottom on. Both top gates are never high together.
- R4: With polarity 1, a trip occurs in any clock where `cmp_above`=1. With polarity 0, a trip occurs in any clock where `cmp_above`=0. A trip removes the modulating top command for the rest of the period, and the bottom gates are unaffected. Without a trip, the modulating top stays on across periods.
- R5: For `blank_cycles` clocks starting at the period edge that applies a changed polarity, trips are ignored. With `dead_cycles`=3, `blank_cycles`=6 and a trip that persists, the new top gate is high for exactly 4 clocks in that period and for none in later periods.
- R6: A gate rises only after its command has been sampled high on `dead_cycles`+1 consecutive edges. It falls at the first edge where its command is sampled low. At a polarity change the two bottom gates are both low for exactly `dead_cycles` clocks.
- R7: The top and bottom gates of one leg are never high together, and an interlock forces both low if the delayed commands ever overlap.
- R8: The top switch of the leg whose bottom is on stays low for the whole half-cycle, whatever `cmp_above` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run enable; low forces all gates off |
| polarity | input | 1 | Requested half-cycle: 1 positive, 0 negative |
| cmp_above | input | 1 | Comparator result: sensed current above reference |
| period_cycles | input | PERIOD_W | Switching period in clocks (at least 2) |
| dead_cycles | input | DT_W | Turn-on delay of every gate in clocks |
| blank_cycles | input | BLANK_W | Trip blanking length after a polarity change |
| gate_hi_a | output | 1 | Leg A top switch gate |
| gate_lo_a | output | 1 | Leg A bottom switch gate |
| gate_hi_b | output | 1 | Leg B top switch gate |
| gate_lo_b | output | 1 | Leg B bottom switch gate |

## Verification
Every gate is registered. A change of command is therefore seen one edge after it forms when it turns a gate off, and `dead_cycles` edges later than that when it turns a gate on. A requested polarity takes effect only at the next period edge, which can be up to `period_cycles` clocks away, and a trip removes the top gate at the edge after the comparator cycle. The bench steps a behavioural model on each rising edge and compares all four gates at each falling edge. Its counted checks measure over windows of whole periods that start after the worst-case latency, so the expected counts (for example 4 blanked on-clocks, or a both-low gap of `dead_cycles`) do not depend on the phase of the period counter.

// File: rtl/hbs_pkg.sv
// Shared definitions for the unipolar bridge sequencer.
// Assumes gate index order: 0 top A, 1 bottom A, 2 top B, 3 bottom B.
package hbs_pkg;

    localparam int NUM_LEGS  = 2;
    localparam int NUM_GATES = 2 * NUM_LEGS;

    // Gate slots in the command vector
    localparam int G_HI_A = 0;
    localparam int G_LO_A = 1;
    localparam int G_HI_B = 2;
    localparam int G_LO_B = 3;

    // One leg of the bridge
    typedef struct packed {
        logic hi;
        logic lo;
    } leg_t;

endpackage

// File: rtl/hbs_period_timer.sv
// Switching period counter.
// Counts 0 .. period_cycles-1 while enabled and flags count zero as the
// first clock of a period. Assumes period_cycles >= 2 and that it only
// changes while the block is disabled.
module hbs_period_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period_cycles,
    output logic [PERIOD_W-1:0] cnt,
    output logic                period_start
);

    logic [PERIOD_W-1:0] last_idx;

    // Index of the final clock of a period
    always_comb last_idx = period_cycles - 1'b1;

    // First clock of a period, only while running
    always_comb period_start = enable && (cnt == '0);

    // Free-running period count, parked at zero while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt <= '0;
        end else if (cnt >= last_idx) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/hbs_polarity_tracker.sv
// Applied half-cycle polarity and zero-crossing trip blanking.
// The requested polarity is taken only at a period start. When that
// changes the applied value, a blank counter is loaded and trips are
// ignored until it has run down. Resets to positive polarity.
module hbs_polarity_tracker #(
    parameter int BLANK_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               period_start,
    input  logic               polarity,
    input  logic [BLANK_W-1:0] blank_cycles,
    output logic               pol_act,
    output logic               blanked
);

    logic [BLANK_W-1:0] blank_cnt;
    logic               pol_flip;

    // A period edge that brings a new polarity
    always_comb pol_flip = period_start && (polarity != pol_act);

    // Blanking is active while the counter is non-zero
    always_comb blanked = (blank_cnt != '0);

    // Applied polarity register, updated on period edges only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_act <= 1'b1;
        end else if (period_start) begin
            pol_act <= polarity;
        end
    end

    // Blank window: load on a polarity change, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank_cnt <= '0;
        end else if (pol_flip) begin
            blank_cnt <= blank_cycles;
        end else if (blanked) begin
            blank_cnt <= blank_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/hbs_trip_latch.sv
// Cycle-by-cycle trip latch with peak or valley sense.
// Positive polarity trips on a high comparator (peak); negative polarity
// trips on a low comparator (valley). Cleared at each period start, set by
// an unblanked trip, held set while disabled.
module hbs_trip_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic period_start,
    input  logic pol_act,
    input  logic blanked,
    input  logic cmp_above,
    output logic tripped
);

    logic trip_hit;

    // Peak sense in the positive half, valley sense in the negative half
    always_comb trip_hit = (pol_act ? cmp_above : !cmp_above) && !blanked;

    // Latch: set dominant within a period, cleared at its start
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            tripped <= 1'b1;
        end else if (period_start) begin
            tripped <= 1'b0;
        end else if (trip_hit) begin
            tripped <= 1'b1;
        end
    end

endmodule

// File: rtl/hbs_dead_time.sv
// Turn-on delay for one gate.
// The gate rises after its command is sampled high on dead_cycles+1
// consecutive edges and falls on the first edge it is sampled low.
// Assumes dead_cycles is only changed while the command is low.
module hbs_dead_time #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd,
    input  logic [DT_W-1:0] dead_cycles,
    output logic            gate
);

    logic [DT_W-1:0] run;

    // Count held-high edges; release the gate once the delay is met
    always_ff @(posedge clk) begin
        if (!rst_n || !cmd) begin
            run  <= '0;
            gate <= 1'b0;
        end else if (run >= dead_cycles) begin
            gate <= 1'b1;
        end else begin
            run <= run + 1'b1;
        end
    end

endmodule

// File: rtl/hbridge_unipolar_seq.sv
// Unipolar H-bridge gate sequencer.
// Decides which leg modulates from the applied polarity, confines trip
// action to the modulating top switch, keeps the opposite bottom switch on
// for the half-cycle, delays every turn-on by the dead time and interlocks
// each leg. All gates are off in reset and while disabled.
module hbridge_unipolar_seq
    import hbs_pkg::*;
#(
    parameter int PERIOD_W = 16,
    parameter int DT_W     = 8,
    parameter int BLANK_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                polarity,
    input  logic                cmp_above,
    input  logic [PERIOD_W-1:0] period_cycles,
    input  logic [DT_W-1:0]     dead_cycles,
    input  logic [BLANK_W-1:0]  blank_cycles,
    output logic                gate_hi_a,
    output logic                gate_lo_a,
    output logic                gate_hi_b,
    output logic                gate_lo_b
);

    logic [PERIOD_W-1:0]  tmr_cnt;
    logic                 period_start;
    logic                 pol_act;
    logic                 blanked;
    logic                 tripped;
    logic [NUM_GATES-1:0] cmd;
    logic [NUM_GATES-1:0] delayed;
    leg_t [NUM_LEGS-1:0]  leg_out;

    hbs_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .period_cycles (period_cycles),
        .cnt           (tmr_cnt),
        .period_start  (period_start)
    );

    hbs_polarity_tracker #(.BLANK_W(BLANK_W)) u_pol (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .polarity     (polarity),
        .blank_cycles (blank_cycles),
        .pol_act      (pol_act),
        .blanked      (blanked)
    );

    hbs_trip_latch u_trip (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .period_start (period_start),
        .pol_act      (pol_act),
        .blanked      (blanked),
        .cmp_above    (cmp_above),
        .tripped      (tripped)
    );

    // Switching pattern: one modulating top, the diagonal bottom held on
    always_comb begin
        cmd         = '0;
        cmd[G_HI_A] = enable &&  pol_act && !tripped;
        cmd[G_LO_A] = enable && !pol_act;
        cmd[G_HI_B] = enable && !pol_act && !tripped;
        cmd[G_LO_B] = enable &&  pol_act;
    end

    // One turn-on delay per gate
    for (genvar g = 0; g < NUM_GATES; g++) begin : g_dead
        hbs_dead_time #(.DT_W(DT_W)) u_dt (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmd         (cmd[g]),
            .dead_cycles (dead_cycles),
            .gate        (delayed[g])
        );
    end

    // Per-leg interlock: an overlap drives both switches of the leg off
    for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
        logic clash;
        always_comb clash = delayed[2*l] && delayed[2*l+1];
        always_comb begin
            leg_out[l].hi = delayed[2*l]   && !clash;
            leg_out[l].lo = delayed[2*l+1] && !clash;
        end
    end

    // Port mapping of the interlocked gates
    always_comb begin
        gate_hi_a = leg_out[0].hi;
        gate_lo_a = leg_out[0].lo;
        gate_hi_b = leg_out[1].hi;
        gate_lo_b = leg_out[1].lo;
    end

endmodule

// File: rtl/hbs_checker.sv
// Property checker for the unipolar sequencer, bound to the top module.
// Assumes period_cycles and dead_cycles change only while disabled.
module hbs_checker #(
    parameter int PERIOD_W = 16,
    parameter int DT_W     = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic [PERIOD_W-1:0] period_cycles,
    input logic [DT_W-1:0]     dead_cycles,
    input logic [PERIOD_W-1:0] cnt,
    input logic                gate_hi_a,
    input logic                gate_lo_a,
    input logic                gate_hi_b,
    input logic                gate_lo_b
);

    // R1
    disabled_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> !(gate_hi_a || gate_lo_a || gate_hi_b || gate_lo_b));

    // R2
    period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && period_cycles >= 2 && cnt < period_cycles) |=> (cnt < period_cycles));

    // R3
    one_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_a && gate_hi_b));

    // R6
    bottom_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_cycles != '0 && $rose(gate_lo_a)) |-> !$past(gate_lo_b));

    // R6
    bottom_gap_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_cycles != '0 && $rose(gate_lo_b)) |-> !$past(gate_lo_a));

    // R7
    leg_a_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_a && gate_lo_a));

    // R7
    leg_b_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_b && gate_lo_b));

endmodule

bind hbridge_unipolar_seq hbs_checker #(.PERIOD_W(PERIOD_W), .DT_W(DT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .period_cycles (period_cycles),
    .dead_cycles   (dead_cycles),
    .cnt           (tmr_cnt),
    .gate_hi_a     (gate_hi_a),
    .gate_lo_a     (gate_lo_a),
    .gate_hi_b     (gate_hi_b),
    .gate_lo_b     (gate_lo_b)
);

// File: tb/tb_hbridge_unipolar_seq.sv
module tb_hbridge_unipolar_seq;

    localparam int PW = 16;
    localparam int DW = 8;
    localparam int BW = 16;
    localparam int PER = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          polarity = 1'b1;
    logic          cmp_above = 1'b0;
    logic [PW-1:0] period_cycles = PW'(PER);
    logic [DW-1:0] dead_cycles = DW'(3);
    logic [BW-1:0] blank_cycles = BW'(6);
    logic          gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    hbridge_unipolar_seq #(.PERIOD_W(PW), .DT_W(DW), .BLANK_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .polarity(polarity),
        .cmp_above(cmp_above), .period_cycles(period_cycles),
        .dead_cycles(dead_cycles), .blank_cycles(blank_cycles),
        .gate_hi_a(gate_hi_a), .gate_lo_a(gate_lo_a),
        .gate_hi_b(gate_hi_b), .gate_lo_b(gate_lo_b)
    );

    // Behavioural reference model, stepped on each rising edge
    int m_cnt, m_blank, m_pol, m_lat;
    int m_run[4];
    int m_out[4];
    always @(posedge clk) begin
        int want[4];
        int pst, eff, n_lat, n_blank, n_pol;
        if (!rst_n) begin
            m_cnt = 0; m_pol = 1; m_blank = 0; m_lat = 1;
            for (int k = 0; k < 4; k++) begin m_run[k] = 0; m_out[k] = 0; end
        end else begin
            pst = (enable && m_cnt == 0) ? 1 : 0;
            eff = m_pol ? int'(cmp_above) : int'(!cmp_above);
            want[0] = (enable && m_pol == 1 && m_lat == 0) ? 1 : 0;
            want[1] = (enable && m_pol == 0) ? 1 : 0;
            want[2] = (enable && m_pol == 0 && m_lat == 0) ? 1 : 0;
            want[3] = (enable && m_pol == 1) ? 1 : 0;
            for (int k = 0; k < 4; k++) begin
                if (want[k] == 0) begin m_run[k] = 0; m_out[k] = 0; end
                else if (m_run[k] >= int'(dead_cycles)) m_out[k] = 1;
                else m_run[k] = m_run[k] + 1;
            end
            if (!enable) n_lat = 1;
            else if (pst == 1) n_lat = 0;
            else if (eff == 1 && m_blank == 0) n_lat = 1;
            else n_lat = m_lat;
            if (pst == 1 && int'(polarity) != m_pol) n_blank = int'(blank_cycles);
            else n_blank = (m_blank > 0) ? m_blank - 1 : 0;
            n_pol = (pst == 1) ? int'(polarity) : m_pol;
            if (!enable) m_cnt = 0;
            else if (m_cnt >= int'(period_cycles) - 1) m_cnt = 0;
            else m_cnt = m_cnt + 1;
            m_lat = n_lat; m_blank = n_blank; m_pol = n_pol;
        end
    end

    task automatic check_int(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check_int(cur_req, "gate_hi_a", int'(gate_hi_a), m_out[0]);
            check_int(cur_req, "gate_lo_a", int'(gate_lo_a), m_out[1]);
            check_int(cur_req, "gate_hi_b", int'(gate_hi_b), m_out[2]);
            check_int(cur_req, "gate_lo_b", int'(gate_lo_b), m_out[3]);
            check_int("R7", "leg overlap", int'((gate_hi_a && gate_lo_a) || (gate_hi_b && gate_lo_b)), 0);
        end
    end

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count high clocks of each gate and both-bottom-low clocks over n cycles
    task automatic measure(int n, output int ha, output int la, output int hb,
                           output int lb, output int gap);
        ha = 0; la = 0; hb = 0; lb = 0; gap = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ha += int'(gate_hi_a); la += int'(gate_lo_a);
            hb += int'(gate_hi_b); lb += int'(gate_lo_b);
            gap += int'(!gate_lo_a && !gate_lo_b);
        end
    endtask

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int ha, la, hb, lb, gap;
        logic [7:0] lfsr;
        int first_rise, second_rise, t;

        // R1: reset holds every gate low
        wait_cycles(4);
        check_int("R1", "reset gate_hi_a", int'(gate_hi_a), 0);
        check_int("R1", "reset gate_lo_a", int'(gate_lo_a), 0);
        check_int("R1", "reset gate_hi_b", int'(gate_hi_b), 0);
        check_int("R1", "reset gate_lo_b", int'(gate_lo_b), 0);
        rst_n = 1'b1;
        wait_cycles(3);

        // R3 R8 R4: positive half, no trip
        cur_req = "R3";
        enable = 1'b1; polarity = 1'b1; cmp_above = 1'b0;
        wait_cycles(2 * PER);
        measure(2 * PER, ha, la, hb, lb, gap);
        check_int("R3", "positive lo_b on-clocks", lb, 2 * PER);
        check_int("R3", "positive lo_a on-clocks", la, 0);
        check_int("R8", "idle top hi_b on-clocks", hb, 0);
        check_int("R4", "untripped hi_a on-clocks", ha, 2 * PER);

        // R4: peak sense, trip every clock keeps the top off
        cur_req = "R4";
        cmp_above = 1'b1;
        wait_cycles(PER);
        measure(2 * PER, ha, la, hb, lb, gap);
        check_int("R4", "peak trip hi_a on-clocks", ha, 0);
        check_int("R4", "bottom unaffected by trip", lb, 2 * PER);

        // R4: varied comparator pattern, model compared every clock
        lfsr = 8'hA5;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cmp_above = lfsr[0] & lfsr[2];
            @(negedge clk);
        end

        // R6: flip to negative half; bottoms both low for dead_cycles clocks
        cur_req = "R6";
        polarity = 1'b0; cmp_above = 1'b1;
        measure(2 * PER, ha, la, hb, lb, gap);
        check_int("R6", "bottom both-low clocks", gap, 3);

        // R3 R4: negative half, valley sense with cmp high means no trip
        cur_req = "R4";
        measure(2 * PER, ha, la, hb, lb, gap);
        check_int("R4", "valley untripped hi_b on-clocks", hb, 2 * PER);
        check_int("R3", "negative lo_a on-clocks", la, 2 * PER);
        check_int("R8", "idle top hi_a on-clocks", ha, 0);
        check_int("R3", "negative lo_b on-clocks", lb, 0);

        // R4: valley sense trips on cmp low
        cmp_above = 1'b0;
        wait_cycles(PER);
        measure(2 * PER, ha, la, hb, lb, gap);
        check_int("R4", "valley trip hi_b on-clocks", hb, 0);

        // R5: flip to positive with a persistent trip; blank lets 4 clocks through
        cur_req = "R5";
        polarity = 1'b1; cmp_above = 1'b1;
        measure(2 * PER, ha, la, hb, lb, gap);
        check_int("R5", "blanked hi_a on-clocks", ha, 4);
        measure(2 * PER, ha, la, hb, lb, gap);
        check_int("R5", "after blank hi_a on-clocks", ha, 0);

        // R1: disable drops all gates at the next edge
        cur_req = "R1";
        enable = 1'b0;
        @(negedge clk);
        check_int("R1", "disabled gate count", int'(gate_hi_a) + int'(gate_lo_a)
                  + int'(gate_hi_b) + int'(gate_lo_b), 0);

        // R2: zero dead time, trip every clock gives one pulse per period
        cur_req = "R2";
        dead_cycles = '0;
        @(negedge clk);
        enable = 1'b1;
        first_rise = -1; second_rise = -1;
        for (t = 0; t < 4 * PER && second_rise < 0; t++) begin
            @(negedge clk);
            if (gate_hi_a && first_rise < 0) first_rise = t;
            else if (gate_hi_a && first_rise >= 0) second_rise = t;
        end
        check_int("R2", "pulse spacing", second_rise - first_rise, PER);

        wait_cycles(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule